// File: doc/BRIEF.md
# Detector Clock Pattern Sequencer

This block produces the timing waveforms that clock an imaging detector array and trigger the conversion and accumulation logic behind it. Waveforms live in an on-chip pattern memory. Every stored word sets 24 phase outputs and 8 strobe outputs, and it carries a dwell count that says how many time-base ticks the word stays on the outputs. A loop-end flag in the word sends the sequence back to a programmed loop address a programmed number of times. Pixel, row and frame timing therefore come entirely from memory contents.

The time base is a tick that fires once every `TICK_DIV` clocks. With the clock rate suited to it, the tick gives 50 ns edge resolution, and a 5-tick pixel gives 250 ns. A host loads pattern words and the four configuration registers while the sequencer is stopped. It then raises `run_i`. When `run_i` is lowered, the word on the outputs completes its dwell, and the outputs then settle to a programmable idle value.

Top module: `pattern_sequencer`

## Requirements
- R1: A pattern word is laid out as phase bits [23:0], strobe bits [31:24], dwell in bits [31+DWELL_W:32] and loop-end flag in the top bit. While a word is active, `phase_o` and `strobe_o` show its phase and strobe fields.
- R2: A word with dwell value d stays on the outputs for exactly d+1 ticks before the next word replaces it.
- R3: A tick occurs on every `TICK_DIV`-th clock after reset is released. `phase_o`, `strobe_o` and `running_o` change only on clock edges where the tick is present.
- R4: While the block is stopped, a tick that sees `run_i` high loads the word at the start address and sets the loop counter to the programmed loop count.
- R5: When a word with the loop-end flag set finishes and the loop counter is non-zero, the next word comes from the loop address and the counter decrements. When the counter is zero, the sequence continues at the next address and the counter reloads. With loop count N, the loop body runs N+1 times.
- R6: If `run_i` is low when the active word's last tick ends, the next tick puts the idle value on the outputs and stops the block. Lowering `run_i` partway through a word does not shorten that word.
- R7: While the block is stopped, each tick drives the idle register onto the outputs: bits [31:24] go to `strobe_o` and bits [23:0] go to `phase_o`. After reset, all outputs and the idle register are zero.
- R8: Configuration writes select a register with `cfg_sel_i`: 0 is the start address, 1 is the loop address, 2 is the loop count and 3 is the idle value. Configuration writes and pattern memory writes take effect only while the block is stopped, and are ignored while it runs.
- R9: `running_o` rises on the start tick and falls on the tick that brings up the idle value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Run request level |
| mem_we_i | input | 1 | Pattern memory write strobe |
| mem_addr_i | input | ADDR_W | Pattern memory write address |
| mem_wdata_i | input | 33+DWELL_W | Pattern word to write |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_sel_i | input | 2 | Configuration register select |
| cfg_wdata_i | input | 32 | Configuration write data |
| phase_o | output | 24 | Detector clock phases |
| strobe_o | output | 8 | Internal strobes (convert, accumulate) |
| running_o | output | 1 | Sequencer active |

## Verification
The bench runs a pattern that contains a multi-tick dwell, a loop body executed three times and a fall-through past the loop-end flag. A design that counts dwell one tick short or one tick long shifts every later entry in the per-tick trace. A loop counter that is off by one adds or drops a whole loop body. A design that fails to reload the counter breaks the later start-address run, which must jump back at once. Two stop cases are tested, one lowering `run_i` mid-dwell and one on a single-tick word, which separates a stop that truncates the word from one that waits for its end. A pattern word and the idle value are both written during a run; the written values would appear in the trace or after the stop if the design failed to ignore them. Every clock is watched for output changes away from a tick edge.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int unsigned NUM_PHASE  = 24;
  localparam int unsigned NUM_STROBE = 8;
  localparam int unsigned OUT_W      = NUM_PHASE + NUM_STROBE;

  typedef enum logic [1:0] {
    CFG_START    = 2'd0,
    CFG_LOOP_ADR = 2'd1,
    CFG_LOOP_CNT = 2'd2,
    CFG_IDLE     = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/seq_tick_gen.sv
module seq_tick_gen #(
  parameter int unsigned TICK_DIV = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (TICK_DIV <= 1) begin : g_every
      logic unused_w;
      assign unused_w = clk_i ^ rst_ni;
      assign tick_o   = 1'b1;
    end else begin : g_div
      localparam int unsigned CW = $clog2(TICK_DIV);
      localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/seq_pattern_ram.sv
module seq_pattern_ram #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned WORD_W = 41
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned DWELL_W = 8,
  parameter int unsigned LOOP_W  = 8,
  localparam int unsigned WORD_W = OUT_W + DWELL_W + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic                  run_i,
  input  logic                  cfg_we_i,
  input  cfg_sel_e              cfg_sel_i,
  input  logic [31:0]           cfg_wdata_i,
  output logic [ADDR_W-1:0]     rd_addr_o,
  input  logic [WORD_W-1:0]     rd_data_i,
  output logic [NUM_PHASE-1:0]  phase_o,
  output logic [NUM_STROBE-1:0] strobe_o,
  output logic                  running_o
);
  logic [ADDR_W-1:0]  start_q, loop_adr_q, addr_q;
  logic [LOOP_W-1:0]  loop_cnt_q, loop_rem_q;
  logic [OUT_W-1:0]   idle_q, out_q;
  logic [DWELL_W-1:0] dwell_q;
  logic               le_q, running_q;

  logic               take_loop;
  logic [DWELL_W-1:0] rd_dwell;
  logic               rd_le;

  assign take_loop = le_q && (loop_rem_q != '0);
  assign rd_dwell  = rd_data_i[OUT_W +: DWELL_W];
  assign rd_le     = rd_data_i[WORD_W-1];

  always_comb begin
    if (!running_q)     rd_addr_o = start_q;
    else if (take_loop) rd_addr_o = loop_adr_q;
    else                rd_addr_o = addr_q + 1'b1;
  end

  // configuration registers, frozen while running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q    <= '0;
      loop_adr_q <= '0;
      loop_cnt_q <= '0;
      idle_q     <= '0;
    end else if (cfg_we_i && !running_q) begin
      unique case (cfg_sel_i)
        CFG_START:    start_q    <= cfg_wdata_i[ADDR_W-1:0];
        CFG_LOOP_ADR: loop_adr_q <= cfg_wdata_i[ADDR_W-1:0];
        CFG_LOOP_CNT: loop_cnt_q <= cfg_wdata_i[LOOP_W-1:0];
        CFG_IDLE:     idle_q     <= cfg_wdata_i[OUT_W-1:0];
        default:      ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q  <= 1'b0;
      addr_q     <= '0;
      dwell_q    <= '0;
      le_q       <= 1'b0;
      loop_rem_q <= '0;
      out_q      <= '0;
    end else if (tick_i) begin
      if (!running_q) begin
        if (run_i) begin
          running_q  <= 1'b1;
          addr_q     <= rd_addr_o;
          out_q      <= rd_data_i[OUT_W-1:0];
          dwell_q    <= rd_dwell;
          le_q       <= rd_le;
          loop_rem_q <= loop_cnt_q;
        end else begin
          out_q <= idle_q;
        end
      end else if (dwell_q != '0) begin
        dwell_q <= dwell_q - 1'b1;
      end else if (!run_i) begin
        running_q <= 1'b0;
        out_q     <= idle_q;
      end else begin
        addr_q  <= rd_addr_o;
        out_q   <= rd_data_i[OUT_W-1:0];
        dwell_q <= rd_dwell;
        le_q    <= rd_le;
        if (le_q) loop_rem_q <= take_loop ? loop_rem_q - 1'b1 : loop_cnt_q;
      end
    end
  end

  assign phase_o   = out_q[NUM_PHASE-1:0];
  assign strobe_o  = out_q[OUT_W-1:NUM_PHASE];
  assign running_o = running_q;
endmodule

// File: rtl/pattern_sequencer.sv
module pattern_sequencer
  import seq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned DWELL_W  = 8,
  parameter int unsigned LOOP_W   = 8,
  parameter int unsigned TICK_DIV = 10,
  localparam int unsigned WORD_W  = OUT_W + DWELL_W + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  run_i,
  input  logic                  mem_we_i,
  input  logic [ADDR_W-1:0]     mem_addr_i,
  input  logic [WORD_W-1:0]     mem_wdata_i,
  input  logic                  cfg_we_i,
  input  logic [1:0]            cfg_sel_i,
  input  logic [31:0]           cfg_wdata_i,
  output logic [NUM_PHASE-1:0]  phase_o,
  output logic [NUM_STROBE-1:0] strobe_o,
  output logic                  running_o
);
  logic              tick_w;
  logic              mem_we_w;
  logic [ADDR_W-1:0] rd_addr_w;
  logic [WORD_W-1:0] rd_data_w;

  assign mem_we_w = mem_we_i && !running_o;

  seq_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick_w)
  );

  seq_pattern_ram #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ram (
    .clk_i   (clk_i),
    .we_i    (mem_we_w),
    .waddr_i (mem_addr_i),
    .wdata_i (mem_wdata_i),
    .raddr_i (rd_addr_w),
    .rdata_o (rd_data_w)
  );

  seq_ctrl #(.ADDR_W(ADDR_W), .DWELL_W(DWELL_W), .LOOP_W(LOOP_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_w),
    .run_i       (run_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_sel_i   (cfg_sel_e'(cfg_sel_i)),
    .cfg_wdata_i (cfg_wdata_i),
    .rd_addr_o   (rd_addr_w),
    .rd_data_i   (rd_data_w),
    .phase_o     (phase_o),
    .strobe_o    (strobe_o),
    .running_o   (running_o)
  );
endmodule

// File: rtl/seq_chk.sv
module seq_chk #(
  parameter int unsigned TICK_DIV = 10
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tick_i,
  input logic        run_i,
  input logic [23:0] phase_o,
  input logic [7:0]  strobe_o,
  input logic        running_o
);
  p_tick_aligned_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({strobe_o, phase_o, running_o}) |-> $past(tick_i));

  p_start_on_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(running_o) |-> $past(run_i) && $past(tick_i));

  p_stop_needs_low_run_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(running_o) |-> !$past(run_i) && $past(tick_i));

  generate
    if (TICK_DIV > 1) begin : g_spacing
      p_tick_spacing_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |=> !tick_i);
    end
  endgenerate
endmodule

bind pattern_sequencer seq_chk #(.TICK_DIV(TICK_DIV)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_w),
  .run_i     (run_i),
  .phase_o   (phase_o),
  .strobe_o  (strobe_o),
  .running_o (running_o)
);

// File: tb/tb_pattern_sequencer.sv
`timescale 1ns/1ps
module tb_pattern_sequencer;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned DW     = 8;
  localparam int unsigned TD     = 3;
  localparam int unsigned WW     = 32 + DW + 1;
  localparam int unsigned NTR    = 17;
  localparam logic [31:0] IDLE_V = 32'h5AA5_A5A5;

  // per-tick {strobe, phase} for start=1, loop addr=2, loop count=2
  localparam logic [31:0] EXP_TR [NTR] = '{
    32'h0100_0011, 32'h0100_0011, 32'h0000_0022,
    32'h8000_0033, 32'h8000_0033, 32'h8000_0033, 32'h0000_0022,
    32'h8000_0033, 32'h8000_0033, 32'h8000_0033, 32'h0000_0022,
    32'h8000_0033, 32'h8000_0033, 32'h8000_0033,
    32'h0000_0044, 32'h0000_0055, 32'h0000_0066
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              run_i = 1'b0;
  logic              mem_we_i = 1'b0;
  logic [ADDR_W-1:0] mem_addr_i = '0;
  logic [WW-1:0]     mem_wdata_i = '0;
  logic              cfg_we_i = 1'b0;
  logic [1:0]        cfg_sel_i = '0;
  logic [31:0]       cfg_wdata_i = '0;
  logic [23:0]       phase_o;
  logic [7:0]        strobe_o;
  logic              running_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int glitches = 0;
  logic [32:0] prev = '0;

  pattern_sequencer #(.ADDR_W(ADDR_W), .DWELL_W(DW), .LOOP_W(8), .TICK_DIV(TD)) dut (
    .clk_i, .rst_ni, .run_i, .mem_we_i, .mem_addr_i, .mem_wdata_i,
    .cfg_we_i, .cfg_sel_i, .cfg_wdata_i, .phase_o, .strobe_o, .running_o
  );

  always #2 clk_i = ~clk_i;

  always @(posedge clk_i) if (rst_ni) cyc <= cyc + 1;

  // R3: no output change after a non-tick edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if ({running_o, strobe_o, phase_o} !== prev && (cyc % TD) != 0) glitches++;
      prev = {running_o, strobe_o, phase_o};
    end
  end

  function automatic logic [WW-1:0] mk(input logic [23:0] ph, input logic [7:0] st,
                                       input logic [DW-1:0] dw, input logic le);
    return {le, dw, st, ph};
  endfunction

  task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick_wait();
    do begin @(posedge clk_i); #1; end while ((cyc % TD) != 0);
    @(negedge clk_i);
  endtask

  task automatic mem_wr(input int a, input logic [WW-1:0] d);
    @(negedge clk_i);
    mem_we_i = 1'b1; mem_addr_i = ADDR_W'(a); mem_wdata_i = d;
    @(negedge clk_i);
    mem_we_i = 1'b0;
  endtask

  task automatic cfg_wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = s; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  function automatic logic [32:0] outs();
    return {running_o, strobe_o, phase_o};
  endfunction

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R7 reset outputs", outs(), 33'h0);
    rst_ni = 1'b1;

    for (int a = 0; a < (1 << ADDR_W); a++) begin
      case (a)
        1:       mem_wr(a, mk(24'h11, 8'h01, 8'd1, 1'b0));
        2:       mem_wr(a, mk(24'h22, 8'h00, 8'd0, 1'b0));
        3:       mem_wr(a, mk(24'h33, 8'h80, 8'd2, 1'b1));
        default: mem_wr(a, mk(24'(a * 17), 8'h00, 8'd0, 1'b0));
      endcase
    end
    cfg_wr(2'd0, 32'd1);
    cfg_wr(2'd1, 32'd2);
    cfg_wr(2'd2, 32'd2);
    cfg_wr(2'd3, IDLE_V);
    tick_wait();
    check("R7 idle value while stopped", outs(), {1'b0, IDLE_V});

    // main trace: dwell, loop x3, fall-through, writes during run
    run_i = 1'b1;
    for (int i = 0; i < NTR; i++) begin
      tick_wait();
      check($sformatf("R1 R2 R5 trace tick %0d", i), outs(), {1'b1, EXP_TR[i]});
      if (i == 0) check("R9 running after start", {32'h0, running_o}, 33'h1);
      if (i == 2) mem_wr(5, mk(24'hFFFFFF, 8'hFF, 8'd0, 1'b0));
      if (i == 3) cfg_wr(2'd3, 32'h00FF_FF00);
    end
    run_i = 1'b0;
    tick_wait();
    check("R6 R8 stop on word end, idle unchanged", outs(), {1'b0, IDLE_V});

    // stop requested mid-dwell: word must finish
    run_i = 1'b1;
    tick_wait();
    check("R4 restart at start address", outs(), {1'b1, 32'h0100_0011});
    run_i = 1'b0;
    tick_wait();
    check("R6 word not cut short", outs(), {1'b1, 32'h0100_0011});
    tick_wait();
    check("R6 idle after dwell", outs(), {1'b0, IDLE_V});
    tick_wait();
    check("R9 stays stopped", outs(), {1'b0, IDLE_V});

    // start inside loop body: counter reloaded at start, jump taken
    cfg_wr(2'd0, 32'd3);
    run_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick_wait();
      check("R4 start at programmed address", outs(), {1'b1, 32'h8000_0033});
    end
    tick_wait();
    check("R5 loop jump after reload", outs(), {1'b1, 32'h0000_0022});
    run_i = 1'b0;
    tick_wait();
    check("R6 stop after single-tick word", outs(), {1'b0, IDLE_V});

    checks++;
    if (glitches != 0) begin
      failures++;
      $display("FAIL R3 mid-tick changes actual=%0d expected=0", glitches);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule